// File: doc/BRIEF.md
# Masked Fuse Burn Sequencer

This block walks a one-time-programmable fuse controller through a complete burn of a pending image. It takes one program word and one mask word per fuse pair, an oscillator code and a start pulse, and then drives the controller's command port (read, write, sense) and its power-good line, one command at a time. Each pair occupies two adjacent array words: the primary at the even address and its shadow copy at the odd address.

A run has three stages. First the master enable bit (bit 0) of words 0 and 1 is burned on its own, and the array is sensed again. Next the primary of every pair is read, and the sequencer keeps only the bits that are requested, allowed by the mask and not yet burned. Finally the pairs are burned from the highest index down to pair 0, primary then shadow. Pairs 1 and 0 hold control fuses, so each of them is followed by a power cycle and a fresh sense. If the array already reports production mode, the run stops before any power is applied unless the request touches only the reserved field.

Every command waits for the controller to report idle. A wait that runs past a fixed bound aborts the run with an error flag.

Top module: `fuse_burn_seq`

## Requirements
- R1: A `start` pulse while `busy` is low raises `busy` on the next cycle and clears `done`, `err_timeout` and `err_reject`. A `start` pulse while `busy` is high has no effect on the command stream.
- R2: A run opens with this sequence: a sense, a read of word 0, a read of word 1, power-good high, a write to word 0, a write to word 1, power-good low, and a sense. Each of the two writes carries only bit 0, set to the inverse of bit 0 of the value just read from that word. Command codes on `cmd_op` are 1 = read, 2 = write, 3 = sense.
- R3: After the opening, the primary word 2i of each pair is read, for i rising from 0 to NPAIR-1. The burn value for pair i is the program word AND the mask word AND NOT the read value. Pair i uses bits [32i+31:32i] of `prog_data` and of `prog_mask`.
- R4: After the scan, power-good goes high and pairs are handled from NPAIR-1 down to 0. A nonzero burn value is written to word 2i and then to word 2i+1. A pair whose burn value is zero issues no write.
- R5: After pair 1 and after pair 0 are handled, the sequencer waits for idle, lowers power-good, issues a sense and raises power-good again. A full run therefore issues exactly four senses.
- R6: After pair 0, power-good is lowered and the sequencer waits for `sense_done`. It then raises `done` and drops `busy`.
- R7: `pulse_cycles` takes the value of `osc_code`, latched at start: 0 gives 130, 1 gives 192, 2 gives 120, 3 gives 260.
- R8: If bit PROD_BIT (default 4) of the word 0 value read in the opening is set and `rsvd_only` is low, the run ends after that read, with `err_reject` and `done` high, no power-good and no write. With `rsvd_only` high the run proceeds normally.
- R9: A command is issued only while `ctrl_idle` is high, and a write only while `pwr_good` is high. While `busy` is low, no command is issued and `pwr_good` stays low.
- R10: If the awaited condition is not seen within IDLE_LIMIT cycles, the run aborts. `err_timeout` and `done` go high, and `busy` and `pwr_good` go low.
- R11: After reset, `busy`, `done`, `err_timeout`, `err_reject`, `pwr_good` and `cmd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for one run |
| rsvd_only | input | 1 | The request touches only the reserved field |
| osc_code | input | 2 | Oscillator frequency code |
| prog_data | input | NPAIR*32 | Program word per pair, held stable while busy |
| prog_mask | input | NPAIR*32 | Mask word per pair, held stable while busy |
| ctrl_idle | input | 1 | Controller is idle |
| ctrl_rdata | input | 32 | Read result, valid when idle returns after a read |
| sense_done | input | 1 | Controller has finished a sense |
| cmd_valid | output | 1 | Command strobe, one cycle |
| cmd_op | output | 2 | Command code: 1 read, 2 write, 3 sense |
| cmd_addr | output | log2(2*NPAIR) | Array word address |
| cmd_wdata | output | 32 | Bits to burn for a write |
| pwr_good | output | 1 | Programming power enable |
| pulse_cycles | output | 9 | Burn pulse length in oscillator cycles |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until the next start |
| err_timeout | output | 1 | Run aborted on an idle timeout |
| err_reject | output | 1 | Run refused because production mode is set |

## Verification
Two functions can fall in the same cycle. A new `start` can arrive in the cycle the sequencer issues a burn write. Separately, the result of a scan read is stored in the same cycle the next command becomes eligible. The bench raises `start` exactly when a write strobe is visible. It then requires the logged command and power stream to match, entry for entry, the stream expected for a single run. It also checks the final array contents, which depend on every scan result having been stored under the right pair index.

// File: rtl/fuse_burn_pkg.sv
package fuse_burn_pkg;

  localparam int FUSE_WORD_W = 32;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_SENSE = 2'd3
  } fuse_op_e;

  typedef enum logic [4:0] {
    PH_IDLE, PH_SENSE0, PH_RD0, PH_RD1, PH_CHECK,
    PH_PWR_ON1, PH_EN0, PH_EN1, PH_PWR_OFF1, PH_SENSE1,
    PH_SCAN, PH_PWR_ON2, PH_BURN_LO, PH_BURN_HI, PH_PAIR_END,
    PH_CTL_OFF, PH_CTL_SENSE, PH_CTL_ON, PH_FIN_OFF, PH_WAIT_SD
  } phase_e;

  localparam logic [1:0] TAG_W0   = 2'd1;
  localparam logic [1:0] TAG_W1   = 2'd2;
  localparam logic [1:0] TAG_SCAN = 2'd3;

  // Burn pulse length per oscillator code
  function automatic logic [8:0] osc_pulse_cycles(input logic [1:0] code);
    case (code)
      2'd0:    return 9'd130;
      2'd1:    return 9'd192;
      2'd2:    return 9'd120;
      default: return 9'd260;
    endcase
  endfunction

  // Bits still to burn: requested, permitted, and not yet blown
  function automatic logic [FUSE_WORD_W-1:0] strip_burned(
      input logic [FUSE_WORD_W-1:0] req,
      input logic [FUSE_WORD_W-1:0] cur,
      input logic [FUSE_WORD_W-1:0] msk);
    return req & ~cur & msk;
  endfunction

  // Master enable value: bit 0 only, when not already blown
  function automatic logic [FUSE_WORD_W-1:0] enable_word(
      input logic [FUSE_WORD_W-1:0] cur);
    return {{(FUSE_WORD_W-1){1'b0}}, ~cur[0]};
  endfunction

endpackage

// File: rtl/fuse_burn_timer.sv
module fuse_burn_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/fuse_burn_store.sv
module fuse_burn_store #(
  parameter int NPAIR = 32,
  parameter int WW    = 32,
  localparam int PIW  = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [PIW-1:0] wr_idx,
  input  logic [WW-1:0]  wr_word,
  input  logic [PIW-1:0] rd_idx,
  output logic [WW-1:0]  rd_word
);
  logic [WW-1:0] words [NPAIR];

  for (genvar g = 0; g < NPAIR; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          words[g] <= '0;
      else if (wr_en && wr_idx == PIW'(g)) words[g] <= wr_word;
    end
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/fuse_burn_pulse.sv
module fuse_burn_pulse (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] code,
  output logic [8:0] cycles
);
  import fuse_burn_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cycles <= '0;
    else if (load) cycles <= osc_pulse_cycles(code);
  end
endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
  import fuse_burn_pkg::*;
#(
  parameter int NPAIR      = 32,
  parameter int IDLE_LIMIT = 1024,
  parameter int PROD_BIT   = 4,
  localparam int WW  = FUSE_WORD_W,
  localparam int AW  = $clog2(2 * NPAIR),
  localparam int PIW = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                rsvd_only,
  input  logic [1:0]          osc_code,
  input  logic [NPAIR*WW-1:0] prog_data,
  input  logic [NPAIR*WW-1:0] prog_mask,
  input  logic                ctrl_idle,
  input  logic [WW-1:0]       ctrl_rdata,
  input  logic                sense_done,
  output logic                cmd_valid,
  output logic [1:0]          cmd_op,
  output logic [AW-1:0]       cmd_addr,
  output logic [WW-1:0]       cmd_wdata,
  output logic                pwr_good,
  output logic [8:0]          pulse_cycles,
  output logic                busy,
  output logic                done,
  output logic                err_timeout,
  output logic                err_reject
);

  phase_e         phase;
  logic           go;
  logic [PIW-1:0] idx;
  logic [PIW-1:0] rd_idx;
  logic           rd_pend;
  logic [1:0]     rd_tag;
  logic [WW-1:0]  cur0, cur1;
  logic           rsvd_q;
  logic           pwr_q, busy_q, done_q, err_t_q, err_r_q;

  // Named events
  logic          ready;
  logic          wait_run;
  logic          expired;
  logic          issue;
  logic          in_burn;
  logic          take_start;
  logic          scan_capture;
  logic [WW-1:0] scan_word;
  logic [WW-1:0] burn_word;
  logic          burn_nz;
  logic [AW-1:0] pair_lo, pair_hi;
  fuse_op_e      op_c;

  assign ready        = (phase == PH_WAIT_SD) ? sense_done : ctrl_idle;
  assign wait_run     = busy_q && !go && !ready;
  assign issue        = busy_q && go;
  assign in_burn      = (phase == PH_BURN_LO) || (phase == PH_BURN_HI);
  assign take_start   = start && !busy_q;
  assign scan_capture = busy_q && !go && ready && rd_pend && (rd_tag == TAG_SCAN);
  assign scan_word    = strip_burned(prog_data[int'(rd_idx)*WW +: WW], ctrl_rdata,
                                     prog_mask[int'(rd_idx)*WW +: WW]);
  assign burn_nz      = |burn_word;
  assign pair_lo      = {idx, 1'b0};
  assign pair_hi      = {idx, 1'b1};

  fuse_burn_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wait_run),
    .expired (expired)
  );

  fuse_burn_store #(.NPAIR(NPAIR), .WW(WW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (scan_capture),
    .wr_idx  (rd_idx),
    .wr_word (scan_word),
    .rd_idx  (idx),
    .rd_word (burn_word)
  );

  fuse_burn_pulse u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (take_start),
    .code   (osc_code),
    .cycles (pulse_cycles)
  );

  // Command decode from the current micro-step
  always_comb begin
    cmd_valid = 1'b0;
    op_c      = OP_NONE;
    cmd_addr  = '0;
    cmd_wdata = '0;
    if (issue) begin
      case (phase)
        PH_SENSE0, PH_SENSE1, PH_CTL_SENSE: begin
          cmd_valid = 1'b1; op_c = OP_SENSE;
        end
        PH_RD0: begin
          cmd_valid = 1'b1; op_c = OP_READ; cmd_addr = AW'(0);
        end
        PH_RD1: begin
          cmd_valid = 1'b1; op_c = OP_READ; cmd_addr = AW'(1);
        end
        PH_SCAN: begin
          cmd_valid = 1'b1; op_c = OP_READ; cmd_addr = pair_lo;
        end
        PH_EN0: begin
          cmd_valid = 1'b1; op_c = OP_WRITE; cmd_addr = AW'(0);
          cmd_wdata = enable_word(cur0);
        end
        PH_EN1: begin
          cmd_valid = 1'b1; op_c = OP_WRITE; cmd_addr = AW'(1);
          cmd_wdata = enable_word(cur1);
        end
        PH_BURN_LO: begin
          if (burn_nz) begin
            cmd_valid = 1'b1; op_c = OP_WRITE; cmd_addr = pair_lo;
            cmd_wdata = burn_word;
          end
        end
        PH_BURN_HI: begin
          cmd_valid = 1'b1; op_c = OP_WRITE; cmd_addr = pair_hi;
          cmd_wdata = burn_word;
        end
        default: ;
      endcase
    end
  end

  assign cmd_op      = op_c;
  assign pwr_good    = pwr_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign err_timeout = err_t_q;
  assign err_reject  = err_r_q;

  // Sequencer: each step waits for ready (wait half), then acts (go half)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      go      <= 1'b0;
      idx     <= '0;
      rd_idx  <= '0;
      rd_pend <= 1'b0;
      rd_tag  <= '0;
      cur0    <= '0;
      cur1    <= '0;
      rsvd_q  <= 1'b0;
      pwr_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_t_q <= 1'b0;
      err_r_q <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        done_q  <= 1'b0;
        err_t_q <= 1'b0;
        err_r_q <= 1'b0;
        rsvd_q  <= rsvd_only;
        rd_pend <= 1'b0;
        go      <= 1'b0;
        phase   <= PH_SENSE0;
      end
    end else if (!go) begin
      if (ready) begin
        go <= 1'b1;
        if (rd_pend) begin
          rd_pend <= 1'b0;
          if (rd_tag == TAG_W0)      cur0 <= ctrl_rdata;
          else if (rd_tag == TAG_W1) cur1 <= ctrl_rdata;
        end
      end else if (expired) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        err_t_q <= 1'b1;
        pwr_q   <= 1'b0;
        phase   <= PH_IDLE;
      end
    end else begin
      go <= 1'b0;
      case (phase)
        PH_SENSE0: phase <= PH_RD0;
        PH_RD0: begin
          rd_pend <= 1'b1; rd_tag <= TAG_W0; phase <= PH_RD1;
        end
        PH_RD1: begin
          rd_pend <= 1'b1; rd_tag <= TAG_W1; phase <= PH_CHECK;
        end
        PH_CHECK: begin
          if (cur0[PROD_BIT] && !rsvd_q) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            err_r_q <= 1'b1;
            phase   <= PH_IDLE;
          end else begin
            phase <= PH_PWR_ON1;
          end
        end
        PH_PWR_ON1:  begin pwr_q <= 1'b1; phase <= PH_EN0; end
        PH_EN0:      phase <= PH_EN1;
        PH_EN1:      phase <= PH_PWR_OFF1;
        PH_PWR_OFF1: begin pwr_q <= 1'b0; phase <= PH_SENSE1; end
        PH_SENSE1:   begin idx <= '0; phase <= PH_SCAN; end
        PH_SCAN: begin
          rd_pend <= 1'b1;
          rd_tag  <= TAG_SCAN;
          rd_idx  <= idx;
          if (int'(idx) == NPAIR - 1) begin
            idx   <= PIW'(NPAIR - 1);
            phase <= PH_PWR_ON2;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_PWR_ON2: begin pwr_q <= 1'b1; phase <= PH_BURN_LO; end
        PH_BURN_LO: phase <= burn_nz ? PH_BURN_HI : PH_PAIR_END;
        PH_BURN_HI: phase <= PH_PAIR_END;
        PH_PAIR_END: begin
          if (int'(idx) < 2) begin
            phase <= PH_CTL_OFF;
          end else begin
            idx   <= idx - 1'b1;
            phase <= PH_BURN_LO;
          end
        end
        PH_CTL_OFF:   begin pwr_q <= 1'b0; phase <= PH_CTL_SENSE; end
        PH_CTL_SENSE: phase <= PH_CTL_ON;
        PH_CTL_ON: begin
          pwr_q <= 1'b1;
          if (idx == '0) begin
            phase <= PH_FIN_OFF;
          end else begin
            idx   <= idx - 1'b1;
            phase <= PH_BURN_LO;
          end
        end
        PH_FIN_OFF: begin pwr_q <= 1'b0; phase <= PH_WAIT_SD; end
        PH_WAIT_SD: begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fuse_burn_seq_chk.sv
module fuse_burn_seq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [AW-1:0] cmd_addr,
  input logic [31:0]   cmd_wdata,
  input logic          ctrl_idle,
  input logic          pwr_good,
  input logic          in_burn,
  input logic          err_timeout
);
  logic          burn_wr;
  logic          lw_v;
  logic [AW-1:0] lw_addr;
  logic [31:0]   lw_data;

  assign burn_wr = cmd_valid && (cmd_op == 2'd2) && in_burn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lw_v    <= 1'b0;
      lw_addr <= '0;
      lw_data <= '0;
    end else if (start && !busy) begin
      lw_v <= 1'b0;
    end else if (burn_wr) begin
      lw_v    <= 1'b1;
      lw_addr <= cmd_addr;
      lw_data <= cmd_wdata;
    end
  end

  AST_CMD_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ctrl_idle); // R9
  AST_WRITE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |-> pwr_good); // R9
  AST_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_valid && !pwr_good)); // R9
  AST_BURN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    burn_wr |-> (cmd_wdata != '0)); // R4
  AST_SHADOW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (burn_wr && cmd_addr[0]) |->
      (lw_v && lw_addr == {cmd_addr[AW-1:1], 1'b0} && lw_data == cmd_wdata)); // R4
  AST_BURN_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (burn_wr && !cmd_addr[0] && lw_v) |-> (cmd_addr < lw_addr)); // R4
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_TIMEOUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> (!pwr_good && done && !busy)); // R10
endmodule

bind fuse_burn_seq fuse_burn_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_addr    (cmd_addr),
  .cmd_wdata   (cmd_wdata),
  .ctrl_idle   (ctrl_idle),
  .pwr_good    (pwr_good),
  .in_burn     (in_burn),
  .err_timeout (err_timeout)
);

// File: tb/fuse_burn_seq_tb.sv
module fuse_burn_seq_tb;
  localparam int NP  = 4;
  localparam int NW  = 2 * NP;
  localparam int AW  = 3;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             start = 1'b0, rsvd_only = 1'b0;
  logic [1:0]       osc_code = 2'd0;
  logic [NP*32-1:0] prog_data = '0, prog_mask = '0;
  logic             m_idle, m_sd;
  logic [31:0]      m_rd;
  logic             cmd_valid, pwr_good, busy, done, err_timeout, err_reject;
  logic [1:0]       cmd_op;
  logic [AW-1:0]    cmd_addr;
  logic [31:0]      cmd_wdata;
  logic [8:0]       pulse_cycles;

  fuse_burn_seq #(.NPAIR(NP), .IDLE_LIMIT(40), .PROD_BIT(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rsvd_only(rsvd_only),
    .osc_code(osc_code), .prog_data(prog_data), .prog_mask(prog_mask),
    .ctrl_idle(m_idle), .ctrl_rdata(m_rd), .sense_done(m_sd),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .pwr_good(pwr_good), .pulse_cycles(pulse_cycles),
    .busy(busy), .done(done), .err_timeout(err_timeout), .err_reject(err_reject)
  );

  int nchk = 0, nfail = 0;

  // Behavioural controller and fuse array; event codes 1 rd, 2 wr, 3 sense, 4 pwr up, 5 pwr down
  logic [31:0] arr [NW];
  int          lg_op [64];
  int          lg_ad [64];
  logic [31:0] lg_dt [64];
  int          lg_n = 0;
  int          viol = 0;
  int          cmd_cnt = 0;
  int          stall_at = 0;
  int          m_cnt = 0, m_num = 0, m_op = 0, m_ad = 0;
  logic [31:0] m_dt;
  logic        pwr_prev = 1'b0;

  task automatic logev(input int op, input int ad, input logic [31:0] dt);
    if (lg_n < 64) begin
      lg_op[lg_n] = op; lg_ad[lg_n] = ad; lg_dt[lg_n] = dt;
    end
    lg_n++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idle <= 1'b1; m_sd <= 1'b0; m_rd <= '0; m_cnt = 0; pwr_prev = 1'b0;
    end else begin
      if (pwr_good != pwr_prev) begin
        logev(pwr_good ? 4 : 5, 0, 0);
        pwr_prev = pwr_good;
      end
      if (m_cnt > 0) begin
        if (cmd_valid) viol++;
        if (m_cnt == 1) begin
          if (!(stall_at != 0 && stall_at == m_num)) begin
            case (m_op)
              1: m_rd <= arr[m_ad];
              2: if (pwr_good) arr[m_ad] = arr[m_ad] | m_dt;
              3: m_sd <= 1'b1;
              default: ;
            endcase
            m_idle <= 1'b1;
            m_cnt = 0;
          end
        end else begin
          m_cnt = m_cnt - 1;
        end
      end else if (cmd_valid) begin
        cmd_cnt++;
        m_num = cmd_cnt;
        m_op = int'(cmd_op); m_ad = int'(cmd_addr);
        m_dt = (cmd_op == 2'd2) ? cmd_wdata : 32'h0;
        logev(m_op, m_ad, m_dt);
        if (cmd_op == 2'd2 && !pwr_good) viol++;
        m_idle <= 1'b0; m_sd <= 1'b0; m_cnt = LAT;
      end
    end
  end

  // Expected model built from the requirements
  logic [31:0] ini [NW];
  logic [31:0] ef  [NW];
  int          ex_op [64];
  int          ex_ad [64];
  logic [31:0] ex_dt [64];
  int          ex_n;

  task automatic push(input int op, input int ad, input logic [31:0] dt);
    ex_op[ex_n] = op; ex_ad[ex_n] = ad; ex_dt[ex_n] = dt; ex_n++;
  endtask

  task automatic build(input logic rsvd, output logic rej);
    logic [31:0] a [NW];
    logic [31:0] b [NP];
    logic [31:0] e0, e1;
    for (int k = 0; k < NW; k++) a[k] = ini[k];
    ex_n = 0;
    push(3, 0, 0); push(1, 0, 0); push(1, 1, 0);
    rej = a[0][4] && !rsvd;
    if (!rej) begin
      e0 = a[0][0] ? 32'h0 : 32'h1;
      e1 = a[1][0] ? 32'h0 : 32'h1;
      push(4, 0, 0); push(2, 0, e0); push(2, 1, e1); push(5, 0, 0); push(3, 0, 0);
      a[0] = a[0] | e0; a[1] = a[1] | e1;
      for (int i = 0; i < NP; i++) begin
        push(1, 2 * i, 0);
        b[i] = prog_data[32*i +: 32] & prog_mask[32*i +: 32] & ~a[2*i];
      end
      push(4, 0, 0);
      for (int i = NP - 1; i >= 0; i--) begin
        if (b[i] != 0) begin
          push(2, 2 * i, b[i]); push(2, 2 * i + 1, b[i]);
          a[2*i] = a[2*i] | b[i]; a[2*i+1] = a[2*i+1] | b[i];
        end
        if (i < 2) begin push(5, 0, 0); push(3, 0, 0); push(4, 0, 0); end
      end
      push(5, 0, 0);
    end
    for (int k = 0; k < NW; k++) ef[k] = a[k];
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [8:0] exp_cycles(input logic [1:0] c);
    logic [8:0] r;
    r = (c[1] ? 9'd120 : 9'd130) + (c[0] ? (c[1] ? 9'd140 : 9'd62) : 9'd0);
    return r;
  endfunction

  task automatic run_case(input logic rsvd, input logic [1:0] osc, input bit mid_start);
    logic rej;
    int   nwr, nse, bad, first;
    for (int k = 0; k < NW; k++) begin ini[k] = arr[k]; end
    build(rsvd, rej);
    lg_n = 0; viol = 0;
    rsvd_only = rsvd; osc_code = osc;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && !done && !err_timeout && !err_reject, "R1", "busy after start",
          {busy, done}, 2'b10);
    if (mid_start) begin
      for (int k = 0; k < 2000 && !(cmd_valid && cmd_op == 2'd2); k++) @(negedge clk);
      start = 1'b1;  // coincides with a write strobe
      @(negedge clk); start = 1'b0;
    end
    for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
    check(done && !busy, "R6", "done at end", {done, busy}, 2'b10);
    check(err_reject == rej && !err_timeout, "R8", "reject flag", err_reject, rej);
    check(pulse_cycles == exp_cycles(osc), "R7", "pulse cycles", pulse_cycles,
          exp_cycles(osc));
    check(lg_n == ex_n, "R5", "event count", lg_n, ex_n);
    bad = 0; first = -1;
    for (int k = 0; k < ex_n && k < lg_n && k < 64; k++)
      if (lg_op[k] != ex_op[k] || lg_ad[k] != ex_ad[k] || lg_dt[k] != ex_dt[k]) begin
        bad++; if (first < 0) first = k;
      end
    if (first >= 0)
      check(0, (first < 8) ? "R2" : "R4", "event stream",
            {lg_op[first], lg_ad[first], lg_dt[first]},
            {ex_op[first], ex_ad[first], ex_dt[first]});
    else
      check(1, "R4", "event stream", 0, 0);
    nwr = 0; nse = 0;
    for (int k = 0; k < lg_n && k < 64; k++) begin
      if (lg_op[k] == 2) nwr++;
      if (lg_op[k] == 3) nse++;
    end
    if (!rej) check(nse == 4, "R5", "sense count", nse, 4);
    else      check(nwr == 0 && !pwr_good, "R8", "writes on reject", nwr, 0);
    for (int k = 0; k < NW; k++)
      check(arr[k] == ef[k], "R3", "array word", arr[k], ef[k]);
    check(viol == 0, "R9", "protocol violations", viol, 0);
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < NP; i++) begin
      logic [31:0] w;
      w = (kind == 0) ? 32'h0 : $urandom;
      if (kind != 3) w[4] = (i == 0) ? 1'b0 : w[4];
      arr[2*i] = w; arr[2*i+1] = w;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NW; k++) arr[k] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!busy && !done && !err_timeout && !err_reject && !pwr_good && !cmd_valid,
          "R11", "reset outputs", {busy, done, err_timeout, err_reject, pwr_good}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full burn of a blank array
    fill(0); prog_data = '1; prog_mask = '1;
    run_case(1'b0, 2'd0, 0);
    // No requested bits: only master enable writes (R4 zero pairs)
    fill(0); prog_data = '0; prog_mask = '1;
    run_case(1'b0, 2'd1, 0);
    // Mask blocks everything
    fill(1); prog_data = '1; prog_mask = '0;
    run_case(1'b0, 2'd2, 0);
    // Random sweeps over all oscillator codes
    for (int r = 0; r < 24; r++) begin
      fill(1);
      for (int i = 0; i < NP; i++) begin
        prog_data[32*i +: 32] = $urandom;
        prog_mask[32*i +: 32] = (r % 3 == 0) ? 32'h0 : $urandom;
      end
      run_case(1'b0, 2'(r % 4), 0);
    end
    // R8: production bit set, general request refused; reserved-only request proceeds
    fill(1); arr[0][4] = 1'b1; arr[1][4] = 1'b1;
    prog_data = '1; prog_mask = '1;
    run_case(1'b0, 2'd3, 0);
    run_case(1'b1, 2'd3, 0);
    // R1: start pulse colliding with a write strobe is ignored
    fill(1); prog_data = {NP{32'hA5A5_5A5A}}; prog_mask = '1;
    run_case(1'b0, 2'd0, 1);

    // R10: controller never returns to idle on the fourth command
    fill(0); prog_data = '1; prog_mask = '1;
    stall_at = cmd_cnt + 4;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
    check(done && err_timeout && !busy && !pwr_good, "R10", "timeout abort",
          {done, err_timeout, busy, pwr_good}, 4'b1100);
    stall_at = 0;
    repeat (10) @(negedge clk);
    check(!cmd_valid && !pwr_good, "R9", "quiet after abort", {cmd_valid, pwr_good}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule